// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between a clock source section and the clock output pins of a desktop clock generator. It receives three source clocks: a CPU-rate clock, a PCI-rate clock and a reference clock. From them it drives a group of CPU clock copies, a group of gated PCI clock copies, one free-running PCI clock and one reference clock. Two active-low stop requests let external power-management logic park the CPU group or the gated PCI group. An active-low power-down input parks every output, including the free-running PCI clock and the reference clock.

Every stop input is asynchronous. The stop requests are sampled on the free-running PCI clock and then carried into the domain of the output they control. Each output group is gated by an enable register that is clocked on the falling edge of that group's own source clock. A gated output therefore always parks low and always restarts with a complete high phase. After power-down is released, a counter on the reference clock models the oscillator wake-up time. No output toggles until that counter has expired and `clocks_valid` is high.

Top module: `clkpm_top`

## Requirements
- R1: While `cpu_stop_n` is low (active low) and the block is awake, every `cpu_clk_o` copy stays low. `pci_clk_o`, `pci_free_o` and `ref_clk_o` keep toggling.
- R2: `cpu_stop_n` passes through two flops on the rising edge of the PCI source clock. Counting from the PCI edge at which the second flop takes the new value: on a stop, 2 or 3 further CPU output rising edges appear; on a restart, 2 or 3 CPU source rising edges pass before the first CPU output rising edge.
- R3: While `pci_stop_n` is low (active low), every `pci_clk_o` copy stays low, and `cpu_clk_o`, `pci_free_o` and `ref_clk_o` keep toggling. No gated PCI rising edge follows the PCI edge at which the second synchronizer flop captures the stop.
- R4: Every gated output parks low and produces only full-width high phases, each equal to half its source period, including the first phase after a restart. All copies within a group are identical.
- R5: After `pwr_dwn_n` (active low) has been low across three reference rising edges, `clocks_valid` is low. Shortly after, every output is low and stops toggling, `ref_clk_o` included.
- R6: While power-down is active, changes on `cpu_stop_n` and `pci_stop_n` produce no output edge.
- R7: After reset release or after `pwr_dwn_n` returns high, `clocks_valid` rises on the WAKE_CYC+1 to WAKE_CYC+3 reference rising edge. Until then every output stays low.
- R8: Once `clocks_valid` is high, each output group runs or stays parked according to the stop inputs present at that time.
- R9: While `rst_n` is low (synchronous, active low), all outputs and `clocks_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_src_clk | input | 1 | CPU-rate source clock |
| pci_src_clk | input | 1 | PCI-rate source clock; sampling clock for the stop requests |
| ref_src_clk | input | 1 | Reference source clock; clocks the wake-up counter |
| rst_n | input | 1 | Synchronous active-low reset, applied in every domain |
| cpu_stop_n | input | 1 | Asynchronous active-low request to park the CPU group |
| pci_stop_n | input | 1 | Asynchronous active-low request to park the gated PCI group |
| pwr_dwn_n | input | 1 | Asynchronous active-low power-down |
| cpu_clk_o | output | CPU_COPIES | Gated CPU clock copies |
| pci_clk_o | output | PCI_COPIES | Gated PCI clock copies |
| pci_free_o | output | 1 | PCI clock, stopped only by power-down |
| ref_clk_o | output | 1 | Reference clock, stopped only by power-down |
| clocks_valid | output | 1 | High once the wake-up interval has elapsed |

## Verification
The bench builds the block with WAKE_CYC set to 16, so both the post-reset wake-up and the post-power-down wake-up finish within a few microseconds. At that count, both edges of the wake window can be measured cycle by cycle. The bench keeps 4 CPU copies and sets 6 PCI copies, which is enough to compare copies within each group. Its three source clocks have unrelated phases and a 1:3 CPU-to-PCI ratio. With these clocks the stop and restart latencies land on measurable edges, and a runt pulse would show up as a wrong high-phase width.

// File: rtl/clkpm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock stop and power-down sequencer.
// Assumes: every crossing uses at least two flops.
package clkpm_pkg;
    localparam int unsigned SYNC_STAGES = 2;

    // Enables produced in the PCI sampling domain
    typedef struct packed {
        logic cpu_run;   // CPU group may run (still crosses into CPU domain)
        logic pci_run;   // gated PCI group may run
        logic free_run;  // free-running PCI output may run
    } pci_en_t;
endpackage

// File: rtl/clkpm_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; reset value is the "stopped" level 0.
module clkpm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkpm_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate feeding COPIES identical outputs.
// The enable is taken on the falling edge of the source, so it only changes
// while the source is low: outputs park low and every high phase is complete.
// Assumes: en is synchronous to clk's rising edge.
module clkpm_gate #(
    parameter int unsigned COPIES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [COPIES-1:0] clk_o
);
    logic en_q;

    // Capture the enable while the source is low
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en;
        end
    end

    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        assign clk_o[i] = clk & en_q;
    end
endmodule

// File: rtl/clkpm_wake.sv
`timescale 1ns/1ps
// Power-down synchronizer and wake-up timer in the reference domain.
// clocks_valid falls two edges after power-down is seen and rises only after
// WAKE_CYC reference cycles of continuous power-on.
// Assumes: WAKE_CYC >= 1.
module clkpm_wake #(
    parameter int unsigned WAKE_CYC = 43000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pwr_dwn_n,
    output logic pwr_on,
    output logic clocks_valid
);
    import clkpm_pkg::*;

    localparam int unsigned CNT_W = $clog2(WAKE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

    logic [CNT_W-1:0] wait_cnt;

    clkpm_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (pwr_dwn_n),
        .q     (pwr_on)
    );

    // Count the wake-up interval; clear it whenever power-down is seen
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            wait_cnt     <= '0;
            clocks_valid <= 1'b0;
        end else if (!pwr_on) begin
            wait_cnt     <= '0;
            clocks_valid <= 1'b0;
        end else if (!clocks_valid) begin
            if (wait_cnt == LAST) begin
                clocks_valid <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkpm_pci_ctl.sv
`timescale 1ns/1ps
// Stop-request sampling on the free-running PCI clock.
// First flop catches each asynchronous request; the second flop also folds in
// the synchronized valid flag, so power-down overrides both requests.
// Assumes: clocks_valid comes from the reference domain (asynchronous here).
module clkpm_pci_ctl (
    input  logic               pci_clk,
    input  logic               rst_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               clocks_valid,
    output clkpm_pkg::pci_en_t en
);
    import clkpm_pkg::*;

    logic cpu_st1;
    logic pci_st1;
    logic pwr_ok;

    clkpm_sync #(.STAGES(SYNC_STAGES)) u_valid_sync (
        .clk   (pci_clk),
        .rst_n (rst_n),
        .d     (clocks_valid),
        .q     (pwr_ok)
    );

    // First synchronizer stage for both stop requests
    always_ff @(posedge pci_clk) begin
        if (!rst_n) begin
            cpu_st1 <= 1'b0;
            pci_st1 <= 1'b0;
        end else begin
            cpu_st1 <= cpu_stop_n;
            pci_st1 <= pci_stop_n;
        end
    end

    // Second stage: qualified run enables, forced off while not valid
    always_ff @(posedge pci_clk) begin
        if (!rst_n) begin
            en <= '0;
        end else begin
            en.cpu_run  <= cpu_st1 & pwr_ok;
            en.pci_run  <= pci_st1 & pwr_ok;
            en.free_run <= pwr_ok;
        end
    end
endmodule

// File: rtl/clkpm_top.sv
`timescale 1ns/1ps
// Clock stop and power-down sequencer: gates CPU and PCI clock groups on
// active-low stop requests and parks every output during power-down.
// Assumes: rst_n is held low for several cycles of the slowest source clock.
module clkpm_top #(
    parameter int unsigned CPU_COPIES = 4,
    parameter int unsigned PCI_COPIES = 6,
    parameter int unsigned WAKE_CYC   = 43000
) (
    input  logic                  cpu_src_clk,
    input  logic                  pci_src_clk,
    input  logic                  ref_src_clk,
    input  logic                  rst_n,
    input  logic                  cpu_stop_n,
    input  logic                  pci_stop_n,
    input  logic                  pwr_dwn_n,
    output logic [CPU_COPIES-1:0] cpu_clk_o,
    output logic [PCI_COPIES-1:0] pci_clk_o,
    output logic                  pci_free_o,
    output logic                  ref_clk_o,
    output logic                  clocks_valid
);
    import clkpm_pkg::*;

    pci_en_t pci_en;
    logic    cpu_run_s;
    logic    pwr_on_s;
    logic    ref_run;

    // Reference domain: power-down sync and wake-up timer
    clkpm_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .ref_clk      (ref_src_clk),
        .rst_n        (rst_n),
        .pwr_dwn_n    (pwr_dwn_n),
        .pwr_on       (pwr_on_s),
        .clocks_valid (clocks_valid)
    );

    // PCI domain: stop request sampling
    clkpm_pci_ctl u_pci_ctl (
        .pci_clk      (pci_src_clk),
        .rst_n        (rst_n),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .clocks_valid (clocks_valid),
        .en           (pci_en)
    );

    // CPU domain: two-flop crossing of the CPU run enable
    clkpm_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
        .clk   (cpu_src_clk),
        .rst_n (rst_n),
        .d     (pci_en.cpu_run),
        .q     (cpu_run_s)
    );

    // Reference output stops as soon as power-down is synchronized
    assign ref_run = pwr_on_s & clocks_valid;

    clkpm_gate #(.COPIES(CPU_COPIES)) u_cpu_gate (
        .clk   (cpu_src_clk),
        .rst_n (rst_n),
        .en    (cpu_run_s),
        .clk_o (cpu_clk_o)
    );

    clkpm_gate #(.COPIES(PCI_COPIES)) u_pci_gate (
        .clk   (pci_src_clk),
        .rst_n (rst_n),
        .en    (pci_en.pci_run),
        .clk_o (pci_clk_o)
    );

    clkpm_gate #(.COPIES(1)) u_free_gate (
        .clk   (pci_src_clk),
        .rst_n (rst_n),
        .en    (pci_en.free_run),
        .clk_o (pci_free_o)
    );

    clkpm_gate #(.COPIES(1)) u_ref_gate (
        .clk   (ref_src_clk),
        .rst_n (rst_n),
        .en    (ref_run),
        .clk_o (ref_clk_o)
    );
endmodule

// File: rtl/clkpm_checker.sv
`timescale 1ns/1ps
// Protocol checker for clkpm_top, attached by bind below.
// Assumes: asynchronous inputs are sampled the same way the design samples them.
module clkpm_checker #(
    parameter int unsigned WAKE_CYC = 43000
) (
    input logic               ref_src_clk,
    input logic               pci_src_clk,
    input logic               rst_n,
    input logic               cpu_stop_n,
    input logic               pci_stop_n,
    input logic               pwr_dwn_n,
    input logic               clocks_valid,
    input clkpm_pkg::pci_en_t pci_en
);
    localparam int unsigned SAT = WAKE_CYC + 8;
    localparam int unsigned CK_W = $clog2(SAT + 1) + 1;

    logic [CK_W-1:0] on_cnt;

    // Count reference cycles of continuous power-on seen at the pin
    always_ff @(posedge ref_src_clk) begin
        if (!rst_n || !pwr_dwn_n) begin
            on_cnt <= '0;
        end else if (int'(on_cnt) != SAT) begin
            on_cnt <= on_cnt + 1'b1;
        end
    end

    // R1: a low CPU request reaches the CPU run enable after two PCI edges
    a_r1_cpu_req_stops: assert property (@(posedge pci_src_clk) disable iff (!rst_n)
        !$past(cpu_stop_n, 2) |-> !pci_en.cpu_run);

    // R3: a low PCI request clears the gated PCI enable after two PCI edges
    a_r3_pci_req_stops: assert property (@(posedge pci_src_clk) disable iff (!rst_n)
        !$past(pci_stop_n, 2) |-> !pci_en.pci_run);

    // R5: power-down clears the valid flag within three reference edges
    a_r5_valid_drops: assert property (@(posedge ref_src_clk) disable iff (!rst_n)
        !$past(pwr_dwn_n, 3) |-> !clocks_valid);

    // R6: while not valid, no run enable survives the crossing
    a_r6_pd_overrides: assert property (@(posedge pci_src_clk) disable iff (!rst_n)
        !$past(clocks_valid, 3) |-> !(pci_en.cpu_run || pci_en.pci_run || pci_en.free_run));

    // R7: valid never rises before the wake-up count has elapsed
    a_r7_wake_not_early: assert property (@(posedge ref_src_clk) disable iff (!rst_n)
        $rose(clocks_valid) |-> (int'(on_cnt) >= WAKE_CYC + 1 && int'(on_cnt) <= WAKE_CYC + 3));

    // R7: valid is up once the wake-up window has clearly passed
    a_r7_wake_not_late: assert property (@(posedge ref_src_clk) disable iff (!rst_n)
        int'(on_cnt) == WAKE_CYC + 4 |-> clocks_valid);
endmodule

bind clkpm_top clkpm_checker #(.WAKE_CYC(WAKE_CYC)) u_chk (
    .ref_src_clk  (ref_src_clk),
    .pci_src_clk  (pci_src_clk),
    .rst_n        (rst_n),
    .cpu_stop_n   (cpu_stop_n),
    .pci_stop_n   (pci_stop_n),
    .pwr_dwn_n    (pwr_dwn_n),
    .clocks_valid (clocks_valid),
    .pci_en       (pci_en)
);

// File: tb/sim_clkpm_top.sv
`timescale 1ns/1ps
// Scoreboard bench for clkpm_top: driver tasks queue expected ranges, a
// monitor process compares them with observed edge counts and latencies.
module sim_clkpm_top;
    localparam int CPU_N = 4;
    localparam int PCI_N = 6;
    localparam int WAKE  = 16;
    localparam int WIN   = 20;

    logic cpu_src = 1'b0;
    logic pci_src = 1'b0;
    logic ref_src = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic pwr_dwn_n = 1'b1;
    logic [CPU_N-1:0] cpu_o;
    logic [PCI_N-1:0] pci_o;
    logic free_o;
    logic ref_o;
    logic valid;

    clkpm_top #(.CPU_COPIES(CPU_N), .PCI_COPIES(PCI_N), .WAKE_CYC(WAKE)) u0 (
        .cpu_src_clk  (cpu_src),
        .pci_src_clk  (pci_src),
        .ref_src_clk  (ref_src),
        .rst_n        (rst_n),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .pwr_dwn_n    (pwr_dwn_n),
        .cpu_clk_o    (cpu_o),
        .pci_clk_o    (pci_o),
        .pci_free_o   (free_o),
        .ref_clk_o    (ref_o),
        .clocks_valid (valid)
    );

    // Source clocks: CPU 100 MHz, PCI 30 ns, reference 70 ns, distinct phases
    always #5 cpu_src = ~cpu_src;
    initial begin #7;  forever #15 pci_src = ~pci_src; end
    initial begin #3;  forever #35 ref_src = ~ref_src; end

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Scoreboard queues
    string exp_req[$];
    string exp_what[$];
    int    exp_lo[$];
    int    exp_hi[$];
    int    act_q[$];
    event  obs_ev;

    task automatic expect_rng(string req, string what, int lo, int hi);
        exp_req.push_back(req); exp_what.push_back(what);
        exp_lo.push_back(lo);   exp_hi.push_back(hi);
    endtask

    task automatic observe(int v);
        act_q.push_back(v);
        ->obs_ev;
    endtask

    task automatic drain();
        while (act_q.size() > 0 && exp_lo.size() > 0) begin
            int a = act_q.pop_front();
            int lo = exp_lo.pop_front();
            int hi = exp_hi.pop_front();
            string rq = exp_req.pop_front();
            string wt = exp_what.pop_front();
            n_cmp++;
            if (a < lo || a > hi) begin
                n_bad++;
                $display("FAIL %s %s: actual %0d expected %0d..%0d", rq, wt, a, lo, hi);
            end
        end
    endtask

    // Monitor: compare results as they are observed
    initial forever begin
        @(obs_ev);
        drain();
    end

    // Edge counters on output copy 0 of each group
    int n_cpu = 0, n_pci = 0, n_free = 0, n_ref = 0;
    always @(posedge cpu_o[0]) n_cpu++;
    always @(posedge pci_o[0]) n_pci++;
    always @(posedge free_o)   n_free++;
    always @(posedge ref_o)    n_ref++;

    // High-phase width monitors (R4)
    realtime t_cpu = 0, t_pci = 0, t_free = 0, t_ref = 0;
    int pw_cpu = 0, pw_pci = 0, pw_free = 0, pw_ref = 0;
    always @(posedge cpu_o[0]) t_cpu = $realtime;
    always @(posedge pci_o[0]) t_pci = $realtime;
    always @(posedge free_o)   t_free = $realtime;
    always @(posedge ref_o)    t_ref = $realtime;
    always @(negedge cpu_o[0]) if (rst_n && ($realtime - t_cpu  < 4.99  || $realtime - t_cpu  > 5.01))  pw_cpu++;
    always @(negedge pci_o[0]) if (rst_n && ($realtime - t_pci  < 14.99 || $realtime - t_pci  > 15.01)) pw_pci++;
    always @(negedge free_o)   if (rst_n && ($realtime - t_free < 14.99 || $realtime - t_free > 15.01)) pw_free++;
    always @(negedge ref_o)    if (rst_n && ($realtime - t_ref  < 34.99 || $realtime - t_ref  > 35.01)) pw_ref++;

    // Copy agreement, sampled inside the source high phase (R4)
    int cp_err = 0;
    always @(posedge cpu_src) begin
        #2;
        if (rst_n && cpu_o != '0 && cpu_o != '1) cp_err++;
    end
    always @(posedge pci_src) begin
        #4;
        if (rst_n && pci_o != '0 && pci_o != '1) cp_err++;
    end

    task automatic zero_cnt();
        n_cpu = 0; n_pci = 0; n_free = 0; n_ref = 0;
    endtask

    // Queue four edge-count expectations and observe the counters
    task automatic check_cnts(string req, bit cpu_run, bit pci_run, bit free_run, bit ref_run);
        expect_rng(req, "cpu edges",  cpu_run  ? 58 : 0, cpu_run  ? 62 : 0);
        observe(n_cpu);
        expect_rng(req, "pci edges",  pci_run  ? 19 : 0, pci_run  ? 21 : 0);
        observe(n_pci);
        expect_rng(req, "free edges", free_run ? 19 : 0, free_run ? 21 : 0);
        observe(n_free);
        expect_rng(req, "ref edges",  ref_run  ? 7 : 0,  ref_run  ? 10 : 0);
        observe(n_ref);
    endtask

    task automatic window(string req, bit c, bit p, bit f, bit r);
        zero_cnt();
        repeat (WIN) @(posedge pci_src);
        #2;
        check_cnts(req, c, p, f, r);
    endtask

    // Wake-up: outputs silent for 8 reference edges, valid within the window (R7)
    task automatic wake_seq();
        int k = 0;
        zero_cnt();
        do begin
            @(posedge ref_src);
            k++;
            #1;
            if (k == 8) begin
                expect_rng("R7", "cpu edges before valid", 0, 0);  observe(n_cpu);
                expect_rng("R7", "pci edges before valid", 0, 0);  observe(n_pci);
                expect_rng("R7", "free edges before valid", 0, 0); observe(n_free);
                expect_rng("R7", "ref edges before valid", 0, 0);  observe(n_ref);
            end
        end while (!valid && k < 200);
        expect_rng("R7", "ref edges until valid", WAKE + 1, WAKE + 3);
        observe(k);
    endtask

    task automatic summary();
        drain();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        // R9: reset holds everything low
        repeat (4) @(posedge pci_src);
        zero_cnt();
        repeat (WIN) @(posedge pci_src);
        #2;
        check_cnts("R9", 0, 0, 0, 0);
        expect_rng("R9", "valid in reset", 0, 0);
        observe(int'(valid));

        @(negedge pci_src) rst_n = 1'b1;
        wake_seq();
        repeat (8) @(posedge pci_src);
        window("R8", 1, 1, 1, 1);

        // R2 stop latency, then R1 isolation
        @(negedge pci_src) cpu_stop_n = 1'b0;
        @(posedge pci_src); @(posedge pci_src);
        #1;
        n_cpu = 0;
        repeat (8) @(posedge cpu_src);
        #1;
        expect_rng("R2", "cpu edges after stop", 2, 3);
        observe(n_cpu);
        window("R1", 0, 1, 1, 1);

        // R2 restart latency
        @(negedge pci_src) cpu_stop_n = 1'b1;
        @(posedge pci_src); @(posedge pci_src);
        #1;
        k = 0;
        for (int i = 0; i < 12; i++) begin
            @(posedge cpu_src);
            k++;
            #1;
            if (cpu_o[0]) break;
        end
        expect_rng("R2", "cpu source edges skipped on restart", 2, 3);
        observe(k - 1);
        repeat (4) @(posedge pci_src);
        window("R2", 1, 1, 1, 1);

        // R3 PCI stop
        @(negedge pci_src) pci_stop_n = 1'b0;
        @(posedge pci_src); @(posedge pci_src);
        #1;
        n_pci = 0;
        repeat (6) @(posedge pci_src);
        #1;
        expect_rng("R3", "pci edges after stop", 0, 0);
        observe(n_pci);
        window("R3", 1, 0, 1, 1);
        @(negedge pci_src) pci_stop_n = 1'b1;
        repeat (4) @(posedge pci_src);
        window("R3", 1, 1, 1, 1);

        // R5 power-down
        @(negedge pci_src) pwr_dwn_n = 1'b0;
        repeat (3) @(posedge ref_src);
        #1;
        expect_rng("R5", "valid after power-down", 0, 0);
        observe(int'(valid));
        repeat (8) @(posedge pci_src);
        window("R5", 0, 0, 0, 0);

        // R6 stop inputs ignored during power-down
        zero_cnt();
        @(negedge pci_src) begin cpu_stop_n = 1'b0; pci_stop_n = 1'b0; end
        repeat (4) @(posedge pci_src);
        @(negedge pci_src) begin cpu_stop_n = 1'b1; pci_stop_n = 1'b1; end
        repeat (10) @(posedge pci_src);
        @(negedge pci_src) cpu_stop_n = 1'b0;
        repeat (6) @(posedge pci_src);
        #2;
        check_cnts("R6", 0, 0, 0, 0);

        // R7/R8 wake with the CPU request still low
        @(negedge pci_src) pwr_dwn_n = 1'b1;
        wake_seq();
        repeat (8) @(posedge pci_src);
        window("R8", 0, 1, 1, 1);
        @(negedge pci_src) cpu_stop_n = 1'b1;
        repeat (6) @(posedge pci_src);
        window("R8", 1, 1, 1, 1);

        // R4 pulse integrity and copy agreement
        expect_rng("R4", "cpu short/long pulses", 0, 0);  observe(pw_cpu);
        expect_rng("R4", "pci short/long pulses", 0, 0);  observe(pw_pci);
        expect_rng("R4", "free short/long pulses", 0, 0); observe(pw_free);
        expect_rng("R4", "ref short/long pulses", 0, 0);  observe(pw_ref);
        expect_rng("R4", "copy disagreements", 0, 0);     observe(cp_err);

        #1;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule